// File: doc/BRIEF.md
# Register-Programmed Power-of-Two Clock Divider

This block takes a reference (crystal) clock and produces a gated output clock whose frequency is the reference divided by 1, 2, 4, 8, 16, 32 or 64. Two byte-wide registers set the divider. One holds a 3-bit factor code. The other holds a run bit. The registers are reached through a plain port with an address, write data, a per-bit write mask, a write strobe and combinational read data. Masked writes change only the bits whose mask bit is set.

Starting and stopping the output is synchronised to the divided clock. The run bit first crosses a two-stage synchroniser in the reference domain. The gate then opens or closes only at the boundary of a divided period, so every output pulse has full width. A factor written while the output runs takes effect at the next divided period boundary, so no period is ever cut short. The intended software sequence is: clear the run bit, wait the stop latency, write the factor, set the run bit.

Top module: `refclk_pow2_div`

## Requirements
- R1: After a synchronous reset the factor code reads 0, the run bit reads 0 and `clk_out` stays low.
- R2: The factor code lives in bits [2:0] at address 0x43. A write there updates only the bits whose `reg_wmask` bit is 1. Bits [7:3] read as 0.
- R3: The run bit is bit 7 at address 0x46, and 1 means running. It changes only when `reg_wmask[7]` is 1. Bits [6:0] read as 0.
- R4: Writes to any address other than 0x43 and 0x46 change nothing, and reads of those addresses return 0.
- R5: With factor code 0 or 1 and the output running, `clk_out` follows the reference clock (divide by 1).
- R6: With factor code n in 2..7 and the output running, `clk_out` has a period of 2^(n-1) reference cycles. Each period is high for the first half and low for the second half.
- R7: After the run bit is set, the first output pulse begins no later than 2 + 3·d reference cycles after the write edge, where d is the division.
- R8: After the run bit is cleared, at most 3 further output periods begin after the write edge, and the output then stays low.
- R9: The output starts and stops only at divided-period boundaries, so the first and last pulses have full width.
- R10: A factor written while running is applied at the end of the current divided period. Every later high or low phase is exactly half of either the old or the new period.
- R11: While the run bit is 0, `clk_out` stays low for any factor code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wmask | input | 8 | Per-bit write mask, 1 = bit is written |
| reg_we | input | 1 | Write strobe, sampled on the rising reference edge |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
The in-line assertions check four things on every cycle. The phase counter never exceeds the current period. The active factor, the gate and the rising edges of the divided output change only at a period boundary. A gate opening is always preceded by a synchronised run request. Masked or misaddressed writes leave the registers untouched. The bench scenarios cover what only the output waveform can show. These are the latency bounds for starting and stopping, the exact period and duty for each factor code, full-width first and last pulses, and the mix of old and new phase lengths when the factor changes while the output runs.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = (1 << CODE_W) - 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  phase_t;

    // state of the divider datapath, all in the reference domain
    typedef struct packed {
        code_t  act;    // factor currently in force
        phase_t ph;     // position within the divided period
        logic   run;    // gate state
        logic   outq;   // registered output for divided modes
    } div_state_t;

    // codes 0 and 1 both select divide-by-1; code n selects 2^(n-1)
    function automatic int unsigned code_shift(code_t c);
        return (c <= code_t'(1)) ? 0 : int'(c) - 1;
    endfunction

    function automatic phase_t period_mask(int unsigned sh);
        return phase_t'(~(phase_t'(~phase_t'(0)) << sh));
    endfunction

    // true while the phase lies in the first (high) half of the period
    function automatic logic in_high_half(phase_t p, int unsigned sh);
        phase_t t;
        if (sh == 0) return 1'b1;
        t = p >> (sh - 1);
        return ~t[0];
    endfunction

endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs
    import refdiv_pkg::*;
#(
    parameter int             ADDR_W      = 8,
    parameter int             DATA_W      = 8,
    parameter logic [ADDR_W-1:0] FACTOR_ADDR = 8'h43,
    parameter logic [ADDR_W-1:0] ENABLE_ADDR = 8'h46,
    parameter int             ENABLE_POS  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    input  logic              we,
    output logic [DATA_W-1:0] rdata,
    output code_t             code,
    output logic              run_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code    <= '0;
            run_req <= 1'b0;
        end else if (we) begin
            if (addr == FACTOR_ADDR)
                code <= (code & ~wmask[CODE_W-1:0]) | (wdata[CODE_W-1:0] & wmask[CODE_W-1:0]);
            if (addr == ENABLE_ADDR && wmask[ENABLE_POS])
                run_req <= wdata[ENABLE_POS];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == FACTOR_ADDR)
            rdata[CODE_W-1:0] = code;
        else if (addr == ENABLE_ADDR)
            rdata[ENABLE_POS] = run_req;
    end

    // R2: a factor write with no mask bits set leaves the code alone
    a_r2_masked_keep: assert property (@(posedge clk) disable iff (rst)
        (we && addr == FACTOR_ADDR && wmask[CODE_W-1:0] == '0) |=> code == $past(code));

    // R4: writes to other addresses touch neither register
    a_r4_other_addr_nowrite: assert property (@(posedge clk) disable iff (rst)
        (we && addr != FACTOR_ADDR && addr != ENABLE_ADDR)
            |=> (code == $past(code) && run_req == $past(run_req)));

endmodule

// File: rtl/refdiv_sync.sv
module refdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/refdiv_core.sv
module refdiv_core
    import refdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_in,
    input  logic  run_sync,
    output logic  clk_out
);

    div_state_t  st, st_n;
    int unsigned sh_cur, sh_nxt;
    logic        period_end;
    logic        cur_div1;
    logic        run_neg;

    always_comb begin
        sh_cur     = code_shift(st.act);
        period_end = (st.ph == period_mask(sh_cur));
        st_n       = st;
        if (period_end) begin
            st_n.act = code_in;
            st_n.ph  = '0;
            st_n.run = run_sync;
        end else begin
            st_n.ph  = st.ph + phase_t'(1);
        end
        sh_nxt    = code_shift(st_n.act);
        st_n.outq = st_n.run && (sh_nxt != 0) && in_high_half(st_n.ph, sh_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    assign cur_div1 = (code_shift(st.act) == 0);

    // divide-by-1 gate changes on the low phase of the reference clock
    always_ff @(negedge clk) begin
        if (rst) run_neg <= 1'b0;
        else     run_neg <= st.run & cur_div1;
    end

    assign clk_out = cur_div1 ? (clk & run_neg) : st.outq;

    // R6: the phase counter stays inside the current period
    a_r6_phase_bound: assert property (@(posedge clk) disable iff (rst)
        st.ph <= period_mask(code_shift(st.act)));

    // R10: a new factor comes into force only at the start of a period
    a_r10_switch_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (st.act != $past(st.act)) |-> st.ph == '0);

    // R9: gate opens and closes only at a period start
    a_r9_gate_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (st.run != $past(st.run)) |-> st.ph == '0);

    // R9: a divided pulse always begins at phase zero
    a_r9_pulse_start: assert property (@(posedge clk) disable iff (rst)
        $rose(st.outq) |-> st.ph == '0);

    // R7: the gate opens only after a synchronised run request
    a_r7_open_after_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(st.run) |-> $past(run_sync));

endmodule

// File: rtl/refclk_pow2_div.sv
module refclk_pow2_div
    import refdiv_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] FACTOR_ADDR = 8'h43,
    parameter logic [ADDR_W-1:0] ENABLE_ADDR = 8'h46,
    parameter int                ENABLE_POS  = 7,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_wmask,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_out
);

    code_t factor_code;
    logic  run_req;
    logic  run_sync;

    refdiv_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .FACTOR_ADDR (FACTOR_ADDR),
        .ENABLE_ADDR (ENABLE_ADDR),
        .ENABLE_POS  (ENABLE_POS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .wmask   (reg_wmask),
        .we      (reg_we),
        .rdata   (reg_rdata),
        .code    (factor_code),
        .run_req (run_req)
    );

    refdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (run_req),
        .q   (run_sync)
    );

    refdiv_core u_core (
        .clk      (clk),
        .rst      (rst),
        .code_in  (factor_code),
        .run_sync (run_sync),
        .clk_out  (clk_out)
    );

endmodule

// File: tb/refclk_pow2_div_tb.sv
module refclk_pow2_div_tb;

    localparam int CLK_P = 10;
    localparam logic [7:0] A_FAC = 8'h43;
    localparam logic [7:0] A_EN  = 8'h46;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_wmask = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    refclk_pow2_div u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wmask (reg_wmask),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .clk_out   (clk_out)
    );

    function automatic int div_of(int code);
        return (code <= 1) ? 1 : (1 << (code - 1));
    endfunction

    function automatic bit pat(int i, int d);
        return (d == 1) ? 1'b1 : ((i % d) < d / 2);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] a, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wmask = m; reg_we = 1'b1;
    endtask

    task automatic sample(output bit s);
        @(posedge clk);
        #3;
        s = clk_out;
        reg_we = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, logic [7:0] m);
        bit s;
        drive(a, d, m);
        sample(s);
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic run_case(int code);
        int  d = div_of(code);
        int  f = -1;
        int  bad = 0;
        int  stop_idx = -1;
        int  after_bad = 0;
        int  hi_seen = 0;
        bit  s;
        bit  prev = 1'b0;
        string rq = (d == 1) ? "R5" : "R6";
        wr(A_FAC, 8'(code), 8'hFF);
        for (int i = 0; i < 70; i++) begin
            sample(s);
            hi_seen += int'(s);
        end
        chk(hi_seen == 0, "R11 disabled output low", hi_seen, 0);
        // set run bit; index 0 is the write edge
        drive(A_EN, 8'h80, 8'h80);
        for (int i = 0; i <= 2 + 3 * d + 4 * d; i++) begin
            sample(s);
            if (f < 0) begin
                if (s && (d == 1 || !prev) && i <= 2 + 3 * d) f = i;
                prev = s;
                if (f < 0 && i == 2 + 3 * d) break;
            end
            if (f >= 0) begin
                if (s != pat(i - f, d)) bad++;
                if (i - f == 4 * d - 1) break;
            end
        end
        chk(f >= 0, "R7 start latency", f, 2 + 3 * d);
        chk(f >= 0 && bad == 0, {rq, " period and duty"}, bad, 0);
        // clear run bit at a period start
        drive(A_EN, 8'h00, 8'h80);
        for (int i = 0; i < 5 * d + 8; i++) begin
            sample(s);
            if (stop_idx < 0) begin
                if (s != pat(i, d)) stop_idx = i;
            end else if (s) begin
                after_bad++;
            end
        end
        chk(stop_idx >= 0 && stop_idx <= 4 * d, "R8 stop latency", stop_idx, 4 * d);
        chk(stop_idx >= 0 && (stop_idx % d) == 0 && after_bad == 0,
            "R9 full last pulse and stays low", after_bad, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit s;
        int hi;
        int seed_dummy;
        seed_dummy = $urandom(32'd7781);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_FAC, v); chk(v == 8'h00, "R1 factor reset", int'(v), 0);
        rd(A_EN, v);  chk(v == 8'h00, "R1 run bit reset", int'(v), 0);
        hi = 0;
        for (int i = 0; i < 10; i++) begin sample(s); hi += int'(s); end
        chk(hi == 0, "R1 output low after reset", hi, 0);

        // R2 masked factor writes and reserved bits
        wr(A_FAC, 8'hFF, 8'hFF);
        rd(A_FAC, v); chk(v == 8'h07, "R2 full write reads 7", int'(v), 7);
        wr(A_FAC, 8'h00, 8'hFE);
        rd(A_FAC, v); chk(v == 8'h01, "R2 masked write keeps bit0", int'(v), 1);
        wr(A_FAC, 8'h06, 8'h00);
        rd(A_FAC, v); chk(v == 8'h01, "R2 zero mask no change", int'(v), 1);

        // R3 run bit needs its mask bit
        wr(A_EN, 8'hFF, 8'h7F);
        rd(A_EN, v); chk(v == 8'h00, "R3 unmasked run bit ignored", int'(v), 0);
        hi = 0;
        for (int i = 0; i < 12; i++) begin sample(s); hi += int'(s); end
        chk(hi == 0, "R3 output stays low", hi, 0);
        wr(A_EN, 8'hFF, 8'hFF);
        rd(A_EN, v); chk(v == 8'h80, "R3 run bit reads bit7 only", int'(v), 128);
        wr(A_EN, 8'h00, 8'h80);
        rd(A_EN, v); chk(v == 8'h00, "R3 run bit cleared", int'(v), 0);
        repeat (80) sample(s);

        // R4 unused addresses
        wr(8'h50, 8'hFF, 8'hFF);
        wr(8'h44, 8'hFF, 8'hFF);
        rd(8'h50, v); chk(v == 8'h00, "R4 unused reads zero", int'(v), 0);
        rd(A_FAC, v); chk(v == 8'h01, "R4 factor untouched", int'(v), 1);
        rd(A_EN, v);  chk(v == 8'h00, "R4 run bit untouched", int'(v), 0);

        // directed corners then random codes
        run_case(0);
        run_case(1);
        run_case(2);
        run_case(7);
        for (int k = 0; k < 5; k++) run_case(int'($urandom % 8));

        // R10 factor change while running: d=4 then d=32
        begin
            int lvl, len, runs, odd, long_runs;
            wr(A_FAC, 8'h03, 8'hFF);
            repeat (70) sample(s);
            wr(A_EN, 8'h80, 8'h80);
            repeat (40) sample(s);
            wr(A_FAC, 8'h06, 8'h07);
            lvl = -1; len = 0; runs = 0; odd = 0; long_runs = 0;
            for (int i = 0; i < 200; i++) begin
                sample(s);
                if (int'(s) == lvl) len++;
                else begin
                    if (runs > 0) begin
                        if (len != 2 && len != 16) odd++;
                        if (len == 16) long_runs++;
                    end
                    if (lvl >= 0) runs++;
                    lvl = int'(s);
                    len = 1;
                end
            end
            chk(odd == 0, "R10 phases half of old or new period", odd, 0);
            chk(long_runs >= 4, "R10 new factor applied", long_runs, 4);
            rd(A_FAC, v); chk(v == 8'h06, "R10 factor readback", int'(v), 6);
            wr(A_EN, 8'h00, 8'h80);
            repeat (100) sample(s);
            hi = 0;
            for (int i = 0; i < 70; i++) begin sample(s); hi += int'(s); end
            chk(hi == 0, "R11 low after stop", hi, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule